// File: doc/BRIEF.md
# CAN Operating-Mode Unit

This block sits between a CAN bit-level protocol engine and the message buffers. It applies the operating mode now in force to three decisions. The first is whether the node may drive the bus, both its own frames and the acknowledge and error-flag bits. The second is which completed, self-sent or broken frames go on to the receive path. The third is whether the error counters run.

Software requests a mode through a 3-bit code. The change is applied only while the protocol engine reports an idle bus, and the mode actually in force is always visible. The unit leaves reset in configuration mode. Loopback feeds the node's own frames back to the receive path as if another node had sent them, and does not care whether they were acknowledged. Listen-only hears everything and drives nothing. When the receive-mode code 11 is set, error-recognition reception stores a frame cut short by an error, with only the bits gathered before the error.

Top module: `canModeCtrl`

## Requirements
- R1: After reset, modeCur is 100 (configuration), and txEnable, ackErrDriveEn, errCntEn, loopbackPath, txPinGpio and storeStrobe are all 0.
- R2: The mode codes are 000 normal, 010 loopback, 011 listen-only and 100 configuration. modeCur takes a requested valid code on the clock edge after the request, and only in a cycle where busIdle is 1. Any other code leaves modeCur unchanged.
- R3: In normal mode, txEnable and ackErrDriveEn are 1. A frame that completes cleanly (frameValid=1, frameError=0) with ownTx=0 is stored, and one with ownTx=1 is not.
- R4: In listen-only and loopback modes, txEnable and ackErrDriveEn are both 0.
- R5: In listen-only mode, every completed frame is stored. Every errored frame is also stored, as a partial frame, whatever rxModeCode is.
- R6: errCntClear pulses for exactly one cycle, in the first cycle that modeCur reads 011. errCntEn is 0 for as long as listen-only is in force.
- R7: In loopback, loopbackPath and txPinGpio are 1. A clean frame with ownTx=1 is stored even when ackMissing=1, and a frame with ownTx=0 is not stored.
- R8: With rxModeCode=11 in normal or loopback mode, a frameError stores a partial frame: storeLen equals bitPos, and data bits at positions at or above bitPos read 0. In normal mode, errCntEn is 1 unless rxModeCode=11, where it is 0. With any other code, errored frames are dropped in these modes.
- R9: In normal mode, a clean own frame (ownTx=1) with ackMissing=1 gives a one-cycle txAckFault pulse on the next cycle. In every other mode, txAckFault stays 0.
- R10: In configuration mode, nothing is stored and txEnable is 0.
- R11: Every store appears on storeStrobe one cycle after its input strobe. storePartial is 1 exactly when the frame ended in error. frameError takes precedence over a simultaneous frameValid, and clean frames keep all their data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| modeReq | input | 3 | Requested operating mode code |
| busIdle | input | 1 | Bus idle indication from the protocol engine |
| rxModeCode | input | 2 | Receive-mode code of the target buffer (11 = error recognition) |
| frameValid | input | 1 | One-cycle strobe: frame completed without error |
| frameError | input | 1 | One-cycle strobe: error detected in the current frame |
| ownTx | input | 1 | The current frame was sent by this node |
| ackMissing | input | 1 | No acknowledge was seen for the current frame |
| bitPos | input | 7 | Bits assembled so far (the error point, or the full length) |
| asmData | input | 64 | Contents of the assembly buffer |
| modeCur | output | 3 | Mode in force |
| txEnable | output | 1 | Node may drive its own frames |
| ackErrDriveEn | output | 1 | Node may drive ACK and error flags |
| txPinGpio | output | 1 | Transmit pin released to general I/O |
| loopbackPath | output | 1 | Transmit output routed internally to receive |
| errCntEn | output | 1 | Error counters may count |
| errCntClear | output | 1 | One-cycle clear of both error counters |
| txAckFault | output | 1 | Own frame unacknowledged, reported to the transmitter |
| storeStrobe | output | 1 | Write strobe to the receive buffer |
| storePartial | output | 1 | Stored frame was cut short by an error |
| storeLen | output | 7 | Valid bit count of the stored frame |
| storeData | output | 64 | Stored frame data |

## Verification
The assertions assume that frameValid and frameError are single-cycle strobes and that ownTx, ackMissing, bitPos and asmData are stable in the cycle of the strobe. They also assume that bitPos never exceeds the data width. The bench drives each frame for exactly one cycle on a falling edge and then returns the strobes to zero. It keeps bitPos within 0..64, and it changes modes only between frames, so that no frame straddles a mode change.

// File: rtl/canModePkg.sv
package canModePkg;

  typedef enum logic [2:0] {
    OPM_NORMAL = 3'b000,
    OPM_LOOP   = 3'b010,
    OPM_LISTEN = 3'b011,
    OPM_CONFIG = 3'b100
  } opModeT;

  localparam logic [1:0] RXM_ERRREC = 2'b11;

  // Strobes and qualifiers handed from control to datapath
  typedef struct packed {
    logic rxForeign;   // clean frames from other nodes accepted
    logic rxOwn;       // clean frames from this node accepted
    logic rxErrAll;    // every errored frame stored
    logic rxErrRec;    // errored frame stored by receive-mode code
    logic ackFaultEn;  // missing ACK reported on own frames
  } dpCtrlT;

  function automatic logic isKnownMode(input logic [2:0] code);
    return (code == OPM_NORMAL) || (code == OPM_LOOP) ||
           (code == OPM_LISTEN) || (code == OPM_CONFIG);
  endfunction

endpackage

// File: rtl/canModeCtl.sv
module canModeCtl
  import canModePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  modeReq,
  input  logic        busIdle,
  input  logic [1:0]  rxModeCode,
  output opModeT      modeCur,
  output logic        txEnable,
  output logic        ackErrDriveEn,
  output logic        txPinGpio,
  output logic        loopbackPath,
  output logic        errCntEn,
  output logic        errCntClear,
  output dpCtrlT      dpCtrl
);

  opModeT modeNext;
  logic   isNormal, isLoop, isListen, errRecSel;

  always_comb begin
    modeNext = modeCur;
    if (busIdle && isKnownMode(modeReq) && (modeReq != modeCur))
      modeNext = opModeT'(modeReq);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeCur     <= OPM_CONFIG;
      errCntClear <= 1'b0;
    end else begin
      modeCur     <= modeNext;
      errCntClear <= (modeNext == OPM_LISTEN) && (modeCur != OPM_LISTEN);
    end
  end

  assign isNormal  = (modeCur == OPM_NORMAL);
  assign isLoop    = (modeCur == OPM_LOOP);
  assign isListen  = (modeCur == OPM_LISTEN);
  assign errRecSel = (rxModeCode == RXM_ERRREC);

  always_comb begin
    txEnable          = isNormal;
    ackErrDriveEn     = isNormal;
    txPinGpio         = isLoop;
    loopbackPath      = isLoop;
    errCntEn          = isNormal && !errRecSel;
    dpCtrl.rxForeign  = isNormal || isListen;
    dpCtrl.rxOwn      = isLoop || isListen;
    dpCtrl.rxErrAll   = isListen;
    dpCtrl.rxErrRec   = (isNormal || isLoop) && errRecSel;
    dpCtrl.ackFaultEn = isNormal;
  end

  // R2
  mode_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeCur != $past(modeCur)) |-> $past(busIdle));

  // R6
  listen_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeCur == OPM_LISTEN) |-> errCntClear);

endmodule

// File: rtl/canModeDp.sv
module canModeDp
  import canModePkg::*;
#(
  parameter int DATA_W = 64,
  localparam int LEN_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrlT            dpCtrl,
  input  logic              frameValid,
  input  logic              frameError,
  input  logic              ownTx,
  input  logic              ackMissing,
  input  logic [LEN_W-1:0]  bitPos,
  input  logic [DATA_W-1:0] asmData,
  output logic              storeStrobe,
  output logic              storePartial,
  output logic [LEN_W-1:0]  storeLen,
  output logic [DATA_W-1:0] storeData,
  output logic              txAckFault
);

  logic              takeErr, takeFull, cleanEnd;
  logic [DATA_W-1:0] keepBit, cutData;

  for (genvar i = 0; i < DATA_W; i++) begin : g_keep
    assign keepBit[i] = (LEN_W'(i) < bitPos);
  end

  assign cleanEnd = frameValid && !frameError;
  assign takeErr  = frameError && (dpCtrl.rxErrAll || dpCtrl.rxErrRec);
  assign takeFull = cleanEnd && (ownTx ? dpCtrl.rxOwn : dpCtrl.rxForeign);
  assign cutData  = frameError ? (asmData & keepBit) : asmData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeStrobe  <= 1'b0;
      storePartial <= 1'b0;
      storeLen     <= '0;
      storeData    <= '0;
      txAckFault   <= 1'b0;
    end else begin
      storeStrobe <= takeErr || takeFull;
      txAckFault  <= cleanEnd && ownTx && ackMissing && dpCtrl.ackFaultEn;
      if (takeErr || takeFull) begin
        storePartial <= frameError;
        storeLen     <= bitPos;
        storeData    <= cutData;
      end
    end
  end

  // R10
  cfg_no_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl == '0) |=> !storeStrobe);

  // R11
  store_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeStrobe |-> $past(frameValid || frameError));

  // R9
  ack_fault_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.ackFaultEn |=> !txAckFault);

endmodule

// File: rtl/canModeCtrl.sv
module canModeCtrl
  import canModePkg::*;
#(
  parameter int DATA_W = 64,
  localparam int LEN_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modeReq,
  input  logic              busIdle,
  input  logic [1:0]        rxModeCode,
  input  logic              frameValid,
  input  logic              frameError,
  input  logic              ownTx,
  input  logic              ackMissing,
  input  logic [LEN_W-1:0]  bitPos,
  input  logic [DATA_W-1:0] asmData,
  output logic [2:0]        modeCur,
  output logic              txEnable,
  output logic              ackErrDriveEn,
  output logic              txPinGpio,
  output logic              loopbackPath,
  output logic              errCntEn,
  output logic              errCntClear,
  output logic              txAckFault,
  output logic              storeStrobe,
  output logic              storePartial,
  output logic [LEN_W-1:0]  storeLen,
  output logic [DATA_W-1:0] storeData
);

  opModeT modeState;
  dpCtrlT dpCtrl;

  assign modeCur = modeState;

  canModeCtl uCtl (
    .clk(clk), .rstN(rstN), .modeReq(modeReq), .busIdle(busIdle),
    .rxModeCode(rxModeCode), .modeCur(modeState), .txEnable(txEnable),
    .ackErrDriveEn(ackErrDriveEn), .txPinGpio(txPinGpio),
    .loopbackPath(loopbackPath), .errCntEn(errCntEn),
    .errCntClear(errCntClear), .dpCtrl(dpCtrl)
  );

  canModeDp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .frameValid(frameValid),
    .frameError(frameError), .ownTx(ownTx), .ackMissing(ackMissing),
    .bitPos(bitPos), .asmData(asmData), .storeStrobe(storeStrobe),
    .storePartial(storePartial), .storeLen(storeLen),
    .storeData(storeData), .txAckFault(txAckFault)
  );

  // R4
  silent_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((modeCur == OPM_LISTEN) || (modeCur == OPM_LOOP)) |->
      (!txEnable && !ackErrDriveEn));

endmodule

// File: tb/canModeCtrl_test.sv
module canModeCtrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int LW = 7;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    modeReq = 3'b100;
  logic          busIdle = 1'b0;
  logic [1:0]    rxModeCode = 2'b00;
  logic          frameValid = 1'b0, frameError = 1'b0, ownTx = 1'b0, ackMissing = 1'b0;
  logic [LW-1:0] bitPos = '0;
  logic [DW-1:0] asmData = '0;
  logic [2:0]    modeCur;
  logic          txEnable, ackErrDriveEn, txPinGpio, loopbackPath;
  logic          errCntEn, errCntClear, txAckFault;
  logic          storeStrobe, storePartial;
  logic [LW-1:0] storeLen;
  logic [DW-1:0] storeData;

  canModeCtrl #(.DATA_W(DW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [DW-1:0] data;
    logic [LW-1:0] len;
    logic          partial;
    string         tag;
  } expItemT;

  expItemT expQ[$];
  int checks = 0;
  int fails = 0;
  logic [2:0] benchMode = 3'b100;

  task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares every store against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && storeStrobe) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R11 unexpected store", storeData, '0);
      end else begin
        expItemT e;
        e = expQ.pop_front();
        chk(storeData === e.data, {e.tag, " data"}, storeData, e.data);
        chk(storeLen === e.len, {e.tag, " len"}, DW'(storeLen), DW'(e.len));
        chk(storePartial === e.partial, {e.tag, " partial"}, DW'(storePartial), DW'(e.partial));
      end
    end
  end

  task automatic setMode(input logic [2:0] m, input logic expectTake);
    @(negedge clk);
    modeReq = m;
    busIdle = 1'b1;
    @(negedge clk);
    if (expectTake) benchMode = m;
    chk(modeCur === benchMode, "R2 mode switch", DW'(modeCur), DW'(benchMode));
  endtask

  task automatic sendFrame(input logic v, input logic e, input logic own, input logic ack,
                           input logic [LW-1:0] len, input logic [DW-1:0] d,
                           input logic expFault, input string tag);
    logic take;
    logic [DW-1:0] ed;
    @(negedge clk);
    frameValid = v; frameError = e; ownTx = own; ackMissing = ack;
    bitPos = len; asmData = d;
    take = 1'b0;
    case (benchMode)
      3'b000: take = e ? (rxModeCode == 2'b11) : (v && !own);
      3'b011: take = e || v;
      3'b010: take = e ? (rxModeCode == 2'b11) : (v && own);
      default: take = 1'b0;
    endcase
    ed = d;
    if (e) for (int i = 0; i < DW; i++) if (i >= len) ed[i] = 1'b0;
    if (take) expQ.push_back('{data: ed, len: len, partial: e, tag: tag});
    @(negedge clk);
    frameValid = 1'b0; frameError = 1'b0; ownTx = 1'b0; ackMissing = 1'b0;
    chk(txAckFault === expFault, {tag, " ackfault"}, DW'(txAckFault), DW'(expFault));
    chk(storeStrobe === take, {tag, " strobe"}, DW'(storeStrobe), DW'(take));
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", '0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(modeCur === 3'b100, "R1 modeCur", DW'(modeCur), 64'd4);
    chk(!txEnable && !ackErrDriveEn && !errCntEn && !loopbackPath && !txPinGpio && !storeStrobe,
        "R1 outputs idle", DW'({txEnable, ackErrDriveEn, errCntEn, loopbackPath, txPinGpio}), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R10 configuration stores nothing
    sendFrame(1, 0, 0, 0, 64, 64'hDEAD_BEEF_0000_1111, 0, "R10 config frame");
    chk(!txEnable, "R10 txEnable", DW'(txEnable), 0);

    // R2 request held while bus busy, then applied
    @(negedge clk);
    modeReq = 3'b000; busIdle = 1'b0;
    repeat (3) @(negedge clk);
    chk(modeCur === 3'b100, "R2 held while busy", DW'(modeCur), 64'd4);
    busIdle = 1'b1;
    @(negedge clk);
    benchMode = 3'b000;
    chk(modeCur === 3'b000, "R2 applied when idle", DW'(modeCur), 0);
    setMode(3'b111, 1'b0);
    setMode(3'b001, 1'b0);

    // R3 normal mode
    chk(txEnable && ackErrDriveEn && errCntEn, "R3 drive enables",
        DW'({txEnable, ackErrDriveEn, errCntEn}), 64'd7);
    sendFrame(1, 0, 0, 0, 64, 64'h0123_4567_89AB_CDEF, 0, "R3 foreign frame");
    sendFrame(1, 0, 1, 0, 64, 64'h5555_AAAA_5555_AAAA, 0, "R3 own frame");
    // R9 missing ACK on own frame in normal mode
    sendFrame(1, 0, 1, 1, 64, 64'h1, 1, "R9 normal ack fault");
    sendFrame(0, 1, 0, 0, 12, 64'hFFFF, 0, "R8 error dropped code00");
    // R8 error recognition
    rxModeCode = 2'b11;
    @(negedge clk);
    chk(!errCntEn, "R8 errCntEn off", DW'(errCntEn), 0);
    sendFrame(0, 1, 0, 0, 20, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R8 partial store");
    sendFrame(0, 1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R8 zero length");
    // R11 error dominates valid
    sendFrame(1, 1, 0, 0, 33, 64'hAAAA_AAAA_AAAA_AAAA, 0, "R11 error over valid");
    rxModeCode = 2'b00;

    // R6 / R5 listen-only
    @(negedge clk);
    modeReq = 3'b011; busIdle = 1'b1;
    @(negedge clk);
    benchMode = 3'b011;
    chk(modeCur === 3'b011, "R6 entered listen", DW'(modeCur), 64'd3);
    chk(errCntClear === 1'b1, "R6 clear pulse", DW'(errCntClear), 1);
    @(negedge clk);
    chk(errCntClear === 1'b0, "R6 clear one cycle", DW'(errCntClear), 0);
    chk(!errCntEn, "R6 counters off", DW'(errCntEn), 0);
    chk(!txEnable && !ackErrDriveEn, "R4 listen silent", DW'({txEnable, ackErrDriveEn}), 0);
    sendFrame(1, 0, 0, 0, 64, 64'hCAFE_F00D_1234_5678, 0, "R5 clean frame");
    sendFrame(0, 1, 0, 0, 40, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R5 errored frame");

    // R7 loopback
    setMode(3'b010, 1'b1);
    chk(loopbackPath && txPinGpio, "R7 path and pin", DW'({loopbackPath, txPinGpio}), 64'd3);
    chk(!txEnable && !ackErrDriveEn, "R4 loop silent", DW'({txEnable, ackErrDriveEn}), 0);
    chk(errCntClear === 1'b0, "R6 no clear outside listen", DW'(errCntClear), 0);
    sendFrame(1, 0, 1, 1, 64, 64'h0F0F_0F0F_F0F0_F0F0, 0, "R7 own frame no ack");
    sendFrame(1, 0, 0, 0, 64, 64'h9999, 0, "R7 foreign ignored");
    rxModeCode = 2'b11;
    sendFrame(0, 1, 1, 0, 8, 64'hFFFF, 0, "R8 loop partial");
    rxModeCode = 2'b00;

    // R10 back to configuration
    setMode(3'b100, 1'b1);
    sendFrame(0, 1, 0, 0, 5, 64'hFF, 0, "R10 config error");

    repeat (2) @(negedge clk);
    chk(expQ.size() == 0, "R11 all stores seen", DW'(expQ.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule